// File: doc/BRIEF.md
# Sixty-Four Line Prioritised Interrupt Controller

This block collects 64 level-sensitive interrupt lines and reduces them to two processor-facing request pins: a normal request, which respects a per-line priority and a global threshold, and a fast request, which fires for any line classed as fast. Software reaches the block through a word-addressed register port. Through that port it enables lines, classes them as normal or fast, and assigns each line a 4-bit priority. Software can also force the pending bits, raise the threshold, and read status views of the pending state.

Software services interrupts by reading one of two vector words. The normal vector word returns the winning normal line and its priority. The fast vector word returns the lowest-numbered fast line. Either read also acknowledges the returned line by clearing its pending bit in the same clock edge. Read data is registered and appears one cycle after the read strobe. Both request pins are registered from the current state.

Top module: `vic64_top`

## Requirements
- R1: After reset, the threshold word (1) reads 0x1F. Every other state word reads 0, both vector words read 0xFFFFFFFF, and both request pins are low.
- R2: Writing word 2 sets enable bit (data & 0x3F), and writing word 3 clears enable bit (data & 0x3F). Reads of words 2 and 3 return 0.
- R3: Words 4 and 6 hold bits 63:32, and words 5 and 7 hold bits 31:0, of the enable and type (1 = fast) vectors respectively. Each word reads back what was written.
- R4: Priority word 15 holds lines 0–7 and word 8 holds lines 56–63. Line n of a word sits at bits 4·(n mod 8)+3 : 4·(n mod 8).
- R5: Reading word 16 returns {line number in bits 31:16, priority in bits 15:0} for the pending, enabled, normal line of highest priority, with ties going to the higher line number, and clears that line's pending bit. With no such line it returns 0xFFFFFFFF. The threshold does not affect this result.
- R6: Reading word 17 returns the lowest-numbered pending, enabled, fast line and clears its pending bit. With no such line it returns 0xFFFFFFFF.
- R7: The threshold keeps only data & 0x1F. The normal pin is high when a pending, enabled, normal line exists and either the threshold equals 0x1F or some such line has priority greater than the threshold.
- R8: The fast pin is high when any line is pending, enabled and fast.
- R9: A write to word 0 stores data & 0x017C0000, so only bits 24 and 22–18 are kept and bit 25 always reads 0.
- R10: Writing word 20 or 21 overwrites the upper or lower half of the pending vector. Writes to words 16–19 and 22–25 change nothing.
- R11: Word 0x40 reads 4. Undefined words read 0. Writes to words 0x40–0xBF change nothing.
- R12: When a vector read clears a line in the same edge that its source is high, the clear wins. A source still held high pends the line again on the next edge.
- R13: A high source sets its pending bit, and a high-to-low source transition clears it. Words 18 and 19 read the pending vector.
- R14: Words 22 and 23 read pending & enable & ~type, and words 24 and 25 read pending & enable & type (high half, then low half).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Level interrupt sources, one per line |
| addr_i | input | 10 | Word address for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe; vector words acknowledge on it |
| rd_data_o | output | 32 | Registered read data, valid the cycle after rd_en_i |
| irq_norm_o | output | 1 | Registered normal request |
| irq_fast_o | output | 1 | Registered fast request |

## Verification
The properties assume that each access presents one address with at most one strobe. They also assume that the enable vector is not rewritten in the cycle after a write to a read-only status word. The stimulus keeps to this by issuing every access in its own two-cycle slot with the strobe low between slots. The sources stay at zero except in the tests of level setting and of ack-versus-set ordering. There a single line is raised and held while its vector word is read, so each expected return value and pin level is known in advance.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC        = 64;
    localparam int DW          = 32;
    localparam int PRIO_W      = 4;
    localparam int MASK_W      = 5;
    localparam int ID_W        = $clog2(NSRC);
    localparam int ADDR_W      = 10;
    localparam int LINES_PER_W = DW / PRIO_W;
    localparam int PRIO_WORDS  = NSRC / LINES_PER_W;
    localparam int HALF        = NSRC / 2;
    localparam int PRIO_TOP    = 15;

    typedef logic [ADDR_W-1:0] waddr_t;

    localparam waddr_t A_CTRL    = 10'd0;
    localparam waddr_t A_THRESH  = 10'd1;
    localparam waddr_t A_EN_NUM  = 10'd2;
    localparam waddr_t A_DIS_NUM = 10'd3;
    localparam waddr_t A_EN_HI   = 10'd4;
    localparam waddr_t A_EN_LO   = 10'd5;
    localparam waddr_t A_TYP_HI  = 10'd6;
    localparam waddr_t A_TYP_LO  = 10'd7;
    localparam waddr_t A_NVEC    = 10'd16;
    localparam waddr_t A_FVEC    = 10'd17;
    localparam waddr_t A_SRC_HI  = 10'd18;
    localparam waddr_t A_SRC_LO  = 10'd19;
    localparam waddr_t A_FRC_HI  = 10'd20;
    localparam waddr_t A_FRC_LO  = 10'd21;
    localparam waddr_t A_NP_HI   = 10'd22;
    localparam waddr_t A_NP_LO   = 10'd23;
    localparam waddr_t A_FP_HI   = 10'd24;
    localparam waddr_t A_FP_LO   = 10'd25;
    localparam waddr_t A_CONST   = 10'h040;

    localparam logic [DW-1:0]     CTRL_KEEP  = 32'h017C_0000;
    localparam logic [DW-1:0]     NO_VEC     = 32'hFFFF_FFFF;
    localparam logic [DW-1:0]     CONST_VAL  = 32'd4;
    localparam logic [MASK_W-1:0] THRESH_ALL = 5'h1F;

    typedef struct packed {
        logic              hit;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] level;
    } npick_t;

    function automatic waddr_t prio_addr(input int word);
        return waddr_t'(PRIO_TOP - word);
    endfunction
endpackage

// File: rtl/vic_norm_arb.sv
module vic_norm_arb
    import vic_pkg::*;
(
    input  logic [NSRC-1:0]        cand_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [MASK_W-1:0]      thresh_i,
    output npick_t                 best_o,
    output logic                   req_o
);
    logic above;

    always_comb begin
        best_o = '0;
        above  = 1'b0;
        // Ascending scan with >= lets a later (higher) line win a tie.
        for (int i = 0; i < NSRC; i++) begin
            if (cand_i[i]) begin
                if (!best_o.hit || prio_i[i*PRIO_W +: PRIO_W] >= best_o.level) begin
                    best_o.hit   = 1'b1;
                    best_o.id    = ID_W'(i);
                    best_o.level = prio_i[i*PRIO_W +: PRIO_W];
                end
                if ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} > thresh_i)
                    above = 1'b1;
            end
        end
        req_o = (|cand_i) && (thresh_i == THRESH_ALL || above);
    end
endmodule

// File: rtl/vic_fast_pick.sv
module vic_fast_pick
    import vic_pkg::*;
(
    input  logic [NSRC-1:0] cand_i,
    output logic            hit_o,
    output logic [ID_W-1:0] id_o
);
    always_comb begin
        hit_o = 1'b0;
        id_o  = '0;
        // Descending scan: the last assignment is the lowest line.
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                hit_o = 1'b1;
                id_o  = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/vic64_top.sv
module vic64_top
    import vic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wr_data_i,
    input  logic              rd_en_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              irq_norm_o,
    output logic              irq_fast_o
);
    logic [DW-1:0]                  ctrl_q, ctrl_d;
    logic [MASK_W-1:0]              mask_q, mask_d;
    logic [NSRC-1:0]                en_q, en_d, type_q, type_d;
    logic [NSRC-1:0]                pend_q, pend_d, src_q;
    logic [PRIO_WORDS-1:0][DW-1:0]  prio_q, prio_d;
    logic [DW-1:0]                  rd_val;

    logic [NSRC-1:0] cand_n, cand_f;
    npick_t          npick;
    logic            norm_req;
    logic            f_hit;
    logic [ID_W-1:0] f_id;

    assign cand_n = pend_q & en_q & ~type_q;
    assign cand_f = pend_q & en_q & type_q;

    vic_norm_arb u_norm (
        .cand_i   (cand_n),
        .prio_i   (prio_q),
        .thresh_i (mask_q),
        .best_o   (npick),
        .req_o    (norm_req)
    );

    vic_fast_pick u_fast (
        .cand_i (cand_f),
        .hit_o  (f_hit),
        .id_o   (f_id)
    );

    // Next-state: source levels, then software writes, then acknowledge.
    always_comb begin
        ctrl_d = ctrl_q;
        mask_d = mask_q;
        en_d   = en_q;
        type_d = type_q;
        prio_d = prio_q;
        pend_d = (pend_q | src_i) & ~(src_q & ~src_i);
        if (wr_en_i) begin
            case (addr_i)
                A_CTRL:    ctrl_d = wr_data_i & CTRL_KEEP;
                A_THRESH:  mask_d = wr_data_i[MASK_W-1:0];
                A_EN_NUM:  en_d[wr_data_i[ID_W-1:0]] = 1'b1;
                A_DIS_NUM: en_d[wr_data_i[ID_W-1:0]] = 1'b0;
                A_EN_HI:   en_d[NSRC-1:HALF] = wr_data_i;
                A_EN_LO:   en_d[HALF-1:0] = wr_data_i;
                A_TYP_HI:  type_d[NSRC-1:HALF] = wr_data_i;
                A_TYP_LO:  type_d[HALF-1:0] = wr_data_i;
                A_FRC_HI:  pend_d[NSRC-1:HALF] = wr_data_i;
                A_FRC_LO:  pend_d[HALF-1:0] = wr_data_i;
                default: begin
                    for (int w = 0; w < PRIO_WORDS; w++)
                        if (addr_i == prio_addr(w)) prio_d[w] = wr_data_i;
                end
            endcase
        end
        if (rd_en_i && addr_i == A_NVEC && npick.hit) pend_d[npick.id] = 1'b0;
        if (rd_en_i && addr_i == A_FVEC && f_hit)     pend_d[f_id]     = 1'b0;
    end

    always_comb begin
        rd_val = '0;
        case (addr_i)
            A_CTRL:   rd_val = ctrl_q;
            A_THRESH: rd_val = DW'(mask_q);
            A_EN_HI:  rd_val = en_q[NSRC-1:HALF];
            A_EN_LO:  rd_val = en_q[HALF-1:0];
            A_TYP_HI: rd_val = type_q[NSRC-1:HALF];
            A_TYP_LO: rd_val = type_q[HALF-1:0];
            A_NVEC:   rd_val = npick.hit ? {16'(npick.id), 16'(npick.level)} : NO_VEC;
            A_FVEC:   rd_val = f_hit ? DW'(f_id) : NO_VEC;
            A_SRC_HI: rd_val = pend_q[NSRC-1:HALF];
            A_SRC_LO: rd_val = pend_q[HALF-1:0];
            A_NP_HI:  rd_val = cand_n[NSRC-1:HALF];
            A_NP_LO:  rd_val = cand_n[HALF-1:0];
            A_FP_HI:  rd_val = cand_f[NSRC-1:HALF];
            A_FP_LO:  rd_val = cand_f[HALF-1:0];
            A_CONST:  rd_val = CONST_VAL;
            default: begin
                for (int w = 0; w < PRIO_WORDS; w++)
                    if (addr_i == prio_addr(w)) rd_val = prio_q[w];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            mask_q     <= THRESH_ALL;
            en_q       <= '0;
            type_q     <= '0;
            pend_q     <= '0;
            src_q      <= '0;
            prio_q     <= '0;
            rd_data_o  <= '0;
            irq_norm_o <= 1'b0;
            irq_fast_o <= 1'b0;
        end else begin
            ctrl_q     <= ctrl_d;
            mask_q     <= mask_d;
            en_q       <= en_d;
            type_q     <= type_d;
            pend_q     <= pend_d;
            src_q      <= src_i;
            prio_q     <= prio_d;
            if (rd_en_i) rd_data_o <= rd_val;
            irq_norm_o <= norm_req;
            irq_fast_o <= |cand_f;
        end
    end
endmodule

// File: rtl/vic64_chk.sv
module vic64_chk
    import vic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [ID_W-1:0]   wr_num,
    input logic              rd_en_i,
    input logic [DW-1:0]     rd_data_o,
    input logic              irq_norm_o,
    input logic              irq_fast_o,
    input logic [NSRC-1:0]   pend_q,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   type_q,
    input logic [MASK_W-1:0] mask_q
);
    p_enable_num_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == A_EN_NUM) |=> en_q[$past(wr_num)]);

    p_disable_num_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == A_DIS_NUM) |=> !en_q[$past(wr_num)]);

    p_fvec_found_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && addr_i == A_FVEC && |(pend_q & en_q & type_q)) |=> rd_data_o != NO_VEC);

    p_norm_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !(|(pend_q & en_q & ~type_q)) |=> !irq_norm_o);

    p_norm_open_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == THRESH_ALL && |(pend_q & en_q & ~type_q)) |=> irq_norm_o);

    p_fast_on_r8: assert property (@(posedge clk) disable iff (rst)
        (|(pend_q & en_q & type_q)) |=> irq_fast_o);

    p_fast_off_r8: assert property (@(posedge clk) disable iff (rst)
        !(|(pend_q & en_q & type_q)) |=> !irq_fast_o);

    p_ro_words_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && ((addr_i >= A_NVEC && addr_i <= A_SRC_LO) ||
                     (addr_i >= A_NP_HI && addr_i <= A_FP_LO)))
        |=> ($stable(en_q) && $stable(type_q) && $stable(mask_q)));
endmodule

bind vic64_top vic64_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_num     (wr_data_i[vic_pkg::ID_W-1:0]),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .irq_norm_o (irq_norm_o),
    .irq_fast_o (irq_fast_o),
    .pend_q     (pend_q),
    .en_q       (en_q),
    .type_q     (type_q),
    .mask_q     (mask_q)
);

// File: tb/vic64_top_tb_top.sv
module vic64_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src = '0;
    logic [9:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq_n, irq_f;

    int compared = 0;
    int mismatched = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    vic64_top dut_i (
        .clk(clk), .rst(rst), .src_i(src), .addr_i(addr),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .irq_norm_o(irq_n), .irq_fast_o(irq_f)
    );

    // Monitor: read data is valid on the negedge after the capturing edge.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (rd_data !== e) begin
                mismatched++;
                $display("FAIL %s: read got %08h expected %08h", t, rd_data, e);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        addr = 10'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string t);
        @(negedge clk);
        addr = 10'(a); rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pins(input logic en, input logic ef, input string t);
        @(negedge clk);
        compared++;
        if (irq_n !== en || irq_f !== ef) begin
            mismatched++;
            $display("FAIL %s: pins got n=%b f=%b expected n=%b f=%b", t, irq_n, irq_f, en, ef);
        end
    endtask

    task automatic set_src(input logic [63:0] v);
        @(negedge clk);
        src = v;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        pins(0, 0, "R1");
        rd(1, 32'h1F, "R1");
        rd(0, 0, "R1");
        rd(5, 0, "R1");
        rd(18, 0, "R1");
        rd(19, 0, "R1");
        rd(16, 32'hFFFF_FFFF, "R1");
        rd(17, 32'hFFFF_FFFF, "R1");
        // R9 control mask
        wr(0, 32'hFFFF_FFFF);
        rd(0, 32'h017C_0000, "R9");
        wr(0, 32'h0300_0000);
        rd(0, 32'h0100_0000, "R9");
        // R2 enable by number
        wr(2, 32'h45);
        wr(2, 32'h3F);
        rd(5, 32'h20, "R2");
        rd(4, 32'h8000_0000, "R2");
        rd(2, 0, "R2");
        rd(3, 0, "R2");
        wr(3, 32'h105);
        rd(5, 0, "R2");
        // R3 halves
        wr(4, 32'h1234_5678);
        rd(4, 32'h1234_5678, "R3");
        wr(7, 32'hF0);
        rd(7, 32'hF0, "R3");
        wr(6, 32'hAB00_0000);
        rd(6, 32'hAB00_0000, "R3");
        wr(4, 0); wr(6, 0); wr(7, 0);
        // R4 priority layout: line0=3, line2=5, line9=5, line63=7
        wr(15, 32'h0000_0503);
        wr(14, 32'h0000_0050);
        wr(8, 32'h7000_0000);
        rd(15, 32'h0000_0503, "R4");
        rd(8, 32'h7000_0000, "R4");
        rd(14, 32'h0000_0050, "R4");
        rd(9, 0, "R4");
        // R10 force and read-only words
        wr(21, 32'h201);
        wr(20, 32'h8000_0000);
        rd(19, 32'h201, "R10");
        rd(18, 32'h8000_0000, "R10");
        wr(18, 0); wr(19, 0);
        rd(19, 32'h201, "R10");
        wr(22, 32'hFFFF_FFFF);
        wr(16, 32'hFFFF_FFFF);
        rd(5, 0, "R10");
        pins(0, 0, "R10");
        // R7 / R14 with lines 0, 9, 63 enabled
        wr(2, 0); wr(2, 9); wr(2, 63);
        pins(1, 0, "R7");
        rd(23, 32'h201, "R14");
        rd(22, 32'h8000_0000, "R14");
        rd(25, 0, "R14");
        rd(24, 0, "R14");
        wr(1, 7);
        pins(0, 0, "R7");
        wr(1, 6);
        pins(1, 0, "R7");
        wr(1, 32'h10);
        pins(0, 0, "R7");
        wr(1, 32'hFFFF_FFE3);
        rd(1, 32'h3, "R7");
        pins(1, 0, "R7");
        wr(1, 32'h1F);
        // R5 normal vector
        rd(16, 32'h003F_0007, "R5");
        rd(16, 32'h0009_0005, "R5");
        rd(16, 32'h0000_0003, "R5");
        rd(16, 32'hFFFF_FFFF, "R5");
        pins(0, 0, "R5");
        wr(2, 2);
        wr(21, 32'h204);
        rd(16, 32'h0009_0005, "R5");
        rd(16, 32'h0002_0005, "R5");
        rd(19, 0, "R5");
        // R6 / R8 fast lines 3 and 40
        wr(7, 32'h8); wr(6, 32'h100);
        wr(2, 3); wr(2, 40);
        wr(21, 32'h8); wr(20, 32'h100);
        pins(0, 1, "R8");
        rd(24, 32'h100, "R14");
        rd(25, 32'h8, "R14");
        rd(16, 32'hFFFF_FFFF, "R5");
        rd(17, 32'd3, "R6");
        rd(17, 32'd40, "R6");
        rd(17, 32'hFFFF_FFFF, "R6");
        pins(0, 0, "R8");
        // R11 constant and ignored regions
        rd(64, 32'd4, "R11");
        rd(30, 0, "R11");
        rd(200, 0, "R11");
        wr(64, 32'hDEAD);
        rd(64, 32'd4, "R11");
        wr(128, 32'hFFFF);
        rd(5, 32'h20D, "R11");
        // R13 source levels on line 10 (priority 0)
        wr(2, 10);
        set_src(64'h400);
        rd(19, 32'h400, "R13");
        pins(1, 0, "R13");
        // R12 ack beats held source, then re-pends
        rd(16, 32'h000A_0000, "R12");
        pins(0, 0, "R12");
        pins(1, 0, "R12");
        set_src(64'h0);
        rd(19, 0, "R13");
        pins(0, 0, "R13");
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog (R1-flow): got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule